// File: doc/BRIEF.md
# PLL Lock Detector by Frequency Variance

This block watches the frequency control word that a digital PLL feeds its oscillator and raises a lock flag once that word has settled. Each new word, flagged by a sample strobe, first goes through a one-pole recursive low-pass filter that tracks the slow mean frequency. The word's departure from that mean is squared. The squares are then averaged by a second one-pole filter of the same form. The result is a mean-square variation figure, and it is exported as the variance estimate.

Both filters use a coefficient of 2^-k, where k is a programmable right shift. For a wanted cutoff Fc at update rate Fs, the ideal coefficient is 1 - exp(-2π·Fc/Fs), and k is picked as the nearest power of two. As an example, k = 4 at a 1 kHz update rate gives a cutoff near 10 Hz. Both accumulators carry extra fractional bits, so small deviations are not lost to truncation.

Lock uses two thresholds for hysteresis. It asserts after the estimate has stayed below an enter threshold for a run of consecutive updates. It drops only when the estimate rises above a separate, larger exit threshold. A clear input restarts the detector from zero.

Top module: `pll_lock_var_det`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `locked` is 0 and `var_est` is 0. Both filter states and the run counter are zero.
- R2: On every edge with `smp_valid` high and `clear` low, the mean state M is updated. M is a two's-complement value with 12 fractional bits, and the input word x is signed. The update is M := M + floor((x·2^12 − M) / 2^k).
- R3: The deviation uses the mean as it was before this sample: d = x − floor(M/2^12). The variance state V has 12 fractional bits and is updated in the same edge as M: V := V + floor((d²·2^12 − V) / 2^k).
- R4: `var_est` equals floor(V/2^12), saturated to 2^32−1. It shows the value written by the most recent accepted sample from the edge that accepts that sample.
- R5: The effective shift k is `shift_k` clamped to the range 2..12. Values 0 and 1 act as 2, and 13 to 15 act as 12.
- R6: A run counter counts consecutive accepted samples whose new `var_est` is strictly below `enter_thr`. `locked` becomes 1 on the sample at which the run reaches HOLD (default 8). Any accepted sample whose new `var_est` is not below `enter_thr` sets the run back to 0.
- R7: `locked` becomes 0 on an accepted sample whose new `var_est` is strictly greater than `exit_thr`. A value between the two thresholds leaves `locked` as it was.
- R8: `clear` high zeroes M, V, the run counter and `locked` on that edge. It takes priority over a sample strobe in the same cycle, and that sample is discarded.
- R9: On an edge with neither `smp_valid` nor `clear`, `var_est` and `locked` keep their values, whatever `freq_word` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Restart: zero both filters and drop lock |
| smp_valid | input | 1 | Strobe: `freq_word` holds a new sample |
| freq_word | input | FREQ_W | Signed oscillator frequency word |
| shift_k | input | 4 | Filter shift k (clamped to 2..12) |
| enter_thr | input | VAR_W | Estimate must stay below this to gain lock |
| exit_thr | input | VAR_W | Estimate above this drops lock |
| locked | output | 1 | Lock flag |
| var_est | output | VAR_W | Mean-square variation estimate (integer part) |

## Verification
Two functions can fall in the same cycle: a clear and a sample strobe. The bench provokes this by asserting both for a single cycle while the detector is locked and its filters hold nonzero state. It then checks that lock has dropped and that the estimate reads zero. It also checks that the next sample evolves as if it were the first one after a restart from zero, which shows the coincident sample left no trace. A second coincidence, the lock counter completing on the same sample that updates the estimate, is judged by predicting that exact sample in a model built from the requirement equations.

// File: rtl/plv_pkg.sv
package plv_pkg;

    localparam int FRAC  = 12;
    localparam int K_MIN = 2;
    localparam int K_MAX = 12;

    typedef struct packed {
        logic below;
        logic above;
    } thr_cmp_t;

    function automatic logic [3:0] clamp_shift(input logic [3:0] k);
        if (k < 4'(K_MIN))      return 4'(K_MIN);
        else if (k > 4'(K_MAX)) return 4'(K_MAX);
        else                    return k;
    endfunction

endpackage

// File: rtl/plv_lpf.sv
module plv_lpf #(
    parameter int IN_W  = 16,
    parameter int ACC_W = IN_W + plv_pkg::FRAC + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    en,
    input  logic [3:0]              shift,
    input  logic signed [IN_W-1:0]  x,
    output logic signed [ACC_W-1:0] acc,
    output logic signed [ACC_W-1:0] acc_nxt
);
    import plv_pkg::*;

    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] diff;

    assign x_ext   = ACC_W'(x) <<< FRAC;
    assign diff    = x_ext - acc;
    assign acc_nxt = acc + (diff >>> shift);

    always_ff @(posedge clk) begin
        if (rst || clear)
            acc <= '0;
        else if (en)
            acc <= acc_nxt;
    end
endmodule

// File: rtl/plv_lock.sv
module plv_lock #(
    parameter int VAR_W = 32,
    parameter int HOLD  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  logic [VAR_W-1:0] var_in,
    input  logic [VAR_W-1:0] enter_thr,
    input  logic [VAR_W-1:0] exit_thr,
    output logic             locked
);
    import plv_pkg::*;

    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD);

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] run_inc;
    thr_cmp_t         cmp;

    assign cmp.below = (var_in < enter_thr);
    assign cmp.above = (var_in > exit_thr);
    assign run_inc   = (run_cnt == HOLD_C) ? run_cnt : run_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_cnt <= '0;
            locked  <= 1'b0;
        end else if (en) begin
            if (cmp.below) begin
                run_cnt <= run_inc;
                if (run_inc == HOLD_C)
                    locked <= 1'b1;
            end else begin
                run_cnt <= '0;
                if (cmp.above)
                    locked <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pll_lock_var_det.sv
module pll_lock_var_det #(
    parameter int FREQ_W = 16,
    parameter int VAR_W  = 32,
    parameter int HOLD   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     smp_valid,
    input  logic signed [FREQ_W-1:0] freq_word,
    input  logic [3:0]               shift_k,
    input  logic [VAR_W-1:0]         enter_thr,
    input  logic [VAR_W-1:0]         exit_thr,
    output logic                     locked,
    output logic [VAR_W-1:0]         var_est
);
    import plv_pkg::*;

    localparam int DEV_W   = FREQ_W + 1;
    localparam int SQ_W    = 2 * DEV_W;
    localparam int M_ACC_W = FREQ_W + FRAC + 2;
    localparam int V_ACC_W = SQ_W + FRAC + 2;
    localparam int VI_W    = V_ACC_W - FRAC;

    logic [3:0]                k_eff;
    logic signed [M_ACC_W-1:0] m_acc, m_nxt, m_int;
    logic signed [V_ACC_W-1:0] v_acc, v_nxt;
    logic signed [DEV_W-1:0]   dev;
    logic signed [SQ_W-1:0]    sq;
    logic [VAR_W-1:0]          var_nxt;
    logic                      take;

    function automatic logic [VAR_W-1:0] sat_var(input logic signed [V_ACC_W-1:0] a);
        logic [VI_W-1:0] w;
        w = VI_W'(a >>> FRAC);
        if (|w[VI_W-1:VAR_W]) return '1;
        else                  return w[VAR_W-1:0];
    endfunction

    assign k_eff = clamp_shift(shift_k);
    assign take  = smp_valid && !clear;

    // Deviation against the mean held before this sample
    assign m_int = m_acc >>> FRAC;
    assign dev   = DEV_W'(freq_word) - m_int[DEV_W-1:0];
    assign sq    = SQ_W'(dev) * SQ_W'(dev);

    plv_lpf #(.IN_W(FREQ_W), .ACC_W(M_ACC_W)) u_mean (
        .clk(clk), .rst(rst), .clear(clear), .en(take), .shift(k_eff),
        .x(freq_word), .acc(m_acc), .acc_nxt(m_nxt)
    );

    plv_lpf #(.IN_W(SQ_W), .ACC_W(V_ACC_W)) u_var (
        .clk(clk), .rst(rst), .clear(clear), .en(take), .shift(k_eff),
        .x(sq), .acc(v_acc), .acc_nxt(v_nxt)
    );

    assign var_est = sat_var(v_acc);
    assign var_nxt = sat_var(v_nxt);

    plv_lock #(.VAR_W(VAR_W), .HOLD(HOLD)) u_lock (
        .clk(clk), .rst(rst), .clear(clear), .en(take),
        .var_in(var_nxt), .enter_thr(enter_thr), .exit_thr(exit_thr),
        .locked(locked)
    );
endmodule

// File: rtl/plv_chk.sv
module plv_chk #(
    parameter int VAR_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             clear,
    input logic             smp_valid,
    input logic [VAR_W-1:0] enter_thr,
    input logic [VAR_W-1:0] exit_thr,
    input logic             locked,
    input logic [VAR_W-1:0] var_est
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!locked && var_est == '0));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!locked && var_est == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !clear) |=> ($stable(var_est) && $stable(locked)));

    // R6
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(smp_valid) && !$past(clear) && var_est < $past(enter_thr)));

    // R7
    lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> ($past(clear) || var_est > $past(exit_thr)));
endmodule

bind pll_lock_var_det plv_chk #(.VAR_W(VAR_W)) u_chk (
    .clk(clk), .rst(rst), .clear(clear), .smp_valid(smp_valid),
    .enter_thr(enter_thr), .exit_thr(exit_thr),
    .locked(locked), .var_est(var_est)
);

// File: tb/pll_lock_var_det_bench.sv
module pll_lock_var_det_bench;
    localparam int HOLD = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               clear = 1'b0;
    logic               smp_valid = 1'b0;
    logic signed [15:0] freq_word = '0;
    logic [3:0]         shift_k = 4'd4;
    logic [31:0]        enter_thr = 32'd50;
    logic [31:0]        exit_thr = 32'd200;
    logic               locked;
    logic [31:0]        var_est;

    int checks = 0;
    int fails  = 0;

    // reference state, from the requirement equations
    longint m_ref = 0, v_ref = 0, vi_ref = 0;
    int     run_ref = 0;
    bit     lk_ref = 0;

    always #5 clk = ~clk;

    pll_lock_var_det u_pll_lock_var_det (
        .clk(clk), .rst(rst), .clear(clear), .smp_valid(smp_valid),
        .freq_word(freq_word), .shift_k(shift_k), .enter_thr(enter_thr),
        .exit_thr(exit_thr), .locked(locked), .var_est(var_est)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_ref = 0; v_ref = 0; vi_ref = 0; run_ref = 0; lk_ref = 0;
    endtask

    task automatic model_step(input int x);
        int kk;
        longint d, sq;
        kk = (shift_k < 2) ? 2 : ((shift_k > 12) ? 12 : int'(shift_k));
        d  = longint'(x) - (m_ref >>> 12);
        sq = d * d;
        m_ref = m_ref + (((longint'(x) <<< 12) - m_ref) >>> kk);
        v_ref = v_ref + (((sq <<< 12) - v_ref) >>> kk);
        vi_ref = v_ref >>> 12;
        if (vi_ref > 64'hFFFF_FFFF) vi_ref = 64'hFFFF_FFFF;
        if (vi_ref < longint'(enter_thr)) begin
            if (run_ref < HOLD) run_ref++;
            if (run_ref == HOLD) lk_ref = 1;
        end else begin
            run_ref = 0;
            if (vi_ref > longint'(exit_thr)) lk_ref = 0;
        end
    endtask

    task automatic sample(input int x, input string req);
        @(negedge clk);
        smp_valid = 1'b1;
        freq_word = 16'(x);
        @(negedge clk);
        smp_valid = 1'b0;
        model_step(x);
        check(longint'(var_est) == vi_ref, req, longint'(var_est), vi_ref);
        check(locked == lk_ref, req, longint'(locked), longint'(lk_ref));
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        model_clear();
    endtask

    task automatic t_reset();
        check(locked == 1'b0, "R1", longint'(locked), 0);
        check(var_est == 32'd0, "R1", longint'(var_est), 0);
    endtask

    task automatic t_steady_lock();
        bit seen_unlocked = 0;
        pulse_clear();
        shift_k = 4'd4;
        for (int i = 0; i < 200; i++) begin
            sample(1000, "R2 R3 R4 R6 steady");
            if (!locked) seen_unlocked = 1;
        end
        check(seen_unlocked, "R6 initially unlocked", 0, 1);
        check(locked == 1'b1, "R6 steady word locks", longint'(locked), 1);
    endtask

    task automatic t_hysteresis();
        for (int i = 0; i < 60; i++)
            sample((i % 2 == 0) ? 1010 : 990, "R7 between thresholds");
        check(locked == 1'b1, "R7 held between thresholds", longint'(locked), 1);
        check(var_est >= enter_thr && var_est <= exit_thr, "R7 estimate in band",
              longint'(var_est), longint'(enter_thr));
        for (int i = 0; i < 60; i++)
            sample((i % 2 == 0) ? 1040 : 960, "R7 exit");
        check(locked == 1'b0, "R7 large variation unlocks", longint'(locked), 0);
    endtask

    task automatic t_clear_with_sample();
        pulse_clear();
        for (int i = 0; i < 200; i++) sample(-300, "R8 relock");
        check(locked == 1'b1, "R8 precondition locked", longint'(locked), 1);
        @(negedge clk);
        clear = 1'b1; smp_valid = 1'b1; freq_word = 16'sd5000;
        @(negedge clk);
        clear = 1'b0; smp_valid = 1'b0;
        model_clear();
        check(locked == 1'b0, "R8 clear beats sample", longint'(locked), 0);
        check(var_est == 32'd0, "R8 clear beats sample", longint'(var_est), 0);
        sample(-300, "R8 restart from zero");
        check(var_est == 32'd5625, "R8 first sample after clear", longint'(var_est), 5625);
    endtask

    task automatic t_shift_clamp();
        pulse_clear();
        shift_k = 4'd0;
        for (int i = 0; i < 20; i++) sample(-20000 + 37 * i, "R5 low clamp");
        pulse_clear();
        shift_k = 4'd15;
        for (int i = 0; i < 20; i++) sample(12000 - 91 * i, "R5 high clamp");
        shift_k = 4'd4;
    endtask

    task automatic t_idle_hold();
        logic [31:0] v0;
        logic        l0;
        v0 = var_est; l0 = locked;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            freq_word = 16'(i * 3001);
        end
        @(negedge clk);
        check(var_est == v0, "R9 idle holds estimate", longint'(var_est), longint'(v0));
        check(locked == l0, "R9 idle holds lock", longint'(locked), longint'(l0));
        sample(11000, "R9 resume");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(locked == 1'b0 && var_est == 32'd0, "R1 in reset", longint'(var_est), 0);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_steady_lock();
        t_hysteresis();
        t_clear_with_sample();
        t_shift_clamp();
        t_idle_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule